// File: doc/BRIEF.md
# Byte and Block Serial Transmitter

This block turns parallel bytes into an asynchronous serial stream on one output line. Each frame is a low start bit, eight data bits sent least significant first, and a high stop interval. One bit lasts a programmable number of system clocks. Between frames the line rests high.

Bytes come from one of two sources, chosen by a mode input. In byte mode a processor write loads a single byte. A ready flag shows when the next write will be taken. In block mode a streaming source offers bytes through a valid/ready handshake, and the stop interval is set by a gap value.

The block holds one byte waiting behind the frame on the line. That slot frees when the last data bit begins, so a source that refills it at once gets frames with no idle time between them.

Top module: `gapped_serial_tx`

## Requirements
- R1: The line `txd` is 1 while idle. A frame drives 0 for the start bit, then data bits 0 through 7 in that order with line level equal to bit value, then 1 for the stop interval.
- R2: Every start, data and stop bit lasts exactly `cfg_rate`+1 clock cycles.
- R3: In byte mode (`cfg_block_mode`=0), a cycle with `wr_en`=1 while `tx_ready`=1 captures `wr_data`, and `tx_ready` reads 0 from the next cycle. When the line was idle, the start bit begins one cycle after that.
- R4: After a byte has been taken, `tx_ready` returns to 1 on the same clock edge at which data bit 7 of that byte's frame begins.
- R5: A `wr_en` pulse while `tx_ready`=0, or while in block mode, has no effect on the line or on the flags.
- R6: In byte mode the stop interval is 2 bit times when `cfg_two_stop`=1 and 1 bit time otherwise.
- R7: When a byte is waiting at the end of a stop interval, its start bit begins on the very next cycle, with no idle bit time.
- R8: `blk_ready` is 1 only in block mode and only while no byte is waiting. A cycle with `blk_valid`=1 and `blk_ready`=1 takes `blk_data`. `blk_valid` has no effect in byte mode. `tx_ready` is 0 in block mode.
- R9: In block mode with `cfg_gap` of 10 or more, the stop interval is `cfg_gap`−9 bit times. The reset gap value of 11 gives 2 bit times.
- R10: In block mode with `cfg_gap` below 10, the stop interval is 1 bit time.
- R11: After reset the line is idle high, nothing is waiting, and `tx_ready` is 1 in byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_block_mode | input | 1 | 0 selects byte mode, 1 selects block mode |
| cfg_two_stop | input | 1 | Byte mode: 1 for two stop bits |
| cfg_rate | input | RATE_W | Bit time minus one, in clocks |
| cfg_gap | input | GAP_W | Block mode gap value (stop = gap−9 bit times) |
| wr_en | input | 1 | Byte mode write strobe |
| wr_data | input | 8 | Byte mode write data |
| tx_ready | output | 1 | Byte mode: a write will be taken |
| blk_valid | input | 1 | Block mode: byte offered |
| blk_data | input | 8 | Block mode: offered byte |
| blk_ready | output | 1 | Block mode: offered byte will be taken |
| txd | output | 1 | Serial output line |

## Verification
The bench aims at these corner cases:
- A rate of zero, where each bit is one clock. A divider that is off by one there stretches or collapses every bit.
- The exact edge at which the ready flag rises. A design that frees the slot at the stop bit instead of bit 7 loses the back-to-back timing.
- Runs of frames written as soon as the slot frees. A design that returns to idle between frames inserts an extra cycle.
- Gap values of 5, 9, 10, 11 and 14. These expose a missing clamp or an off-by-one in the gap subtraction.
- Writes issued while busy or in the wrong mode. A design that fails to ignore them corrupts the byte on the line.

// File: rtl/gtx_pkg.sv
package gtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } gtx_state_e;

    localparam int unsigned DATA_BITS = 8;

endpackage

// File: rtl/gtx_baud_tick.sv
module gtx_baud_tick #(
    parameter int unsigned RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [RATE_W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q >= rate);

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + RATE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/gtx_stop_len.sv
module gtx_stop_len #(
    parameter int unsigned GAP_W = 8
) (
    input  logic             block_mode,
    input  logic             two_stop,
    input  logic [GAP_W-1:0] gap,
    output logic [GAP_W-1:0] stop_bits
);

    localparam logic [GAP_W-1:0] GAP_FLOOR  = GAP_W'(10);
    localparam logic [GAP_W-1:0] GAP_OFFSET = GAP_W'(9);

    always_comb begin
        if (block_mode) begin
            // values under the floor clamp to a single stop bit
            stop_bits = (gap >= GAP_FLOOR) ? (gap - GAP_OFFSET) : GAP_W'(1);
        end else begin
            stop_bits = two_stop ? GAP_W'(2) : GAP_W'(1);
        end
    end

endmodule

// File: rtl/gapped_serial_tx.sv
module gapped_serial_tx
    import gtx_pkg::*;
#(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_block_mode,
    input  logic              cfg_two_stop,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic              tx_ready,
    input  logic              blk_valid,
    input  logic [7:0]        blk_data,
    output logic              blk_ready,
    output logic              txd
);

    localparam int unsigned CNT_W     = (GAP_W > 3) ? GAP_W : 3;
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_BITS - 1);
    localparam logic [CNT_W-1:0] FREE_BIT  = CNT_W'(DATA_BITS - 2);

    typedef struct packed {
        gtx_state_e             state;
        logic [CNT_W-1:0]       cnt;      // data bit index, or stop bits left
        logic [DATA_BITS-1:0]   shreg;
        logic [DATA_BITS-1:0]   hold;
        logic                   hold_full;
    } gtx_regs_t;

    gtx_regs_t r_d, r_q;

    logic             tick;
    logic [GAP_W-1:0] stop_bits;
    logic             line_busy;
    logic             take_byte;
    logic             take_blk;

    assign line_busy = (r_q.state != ST_IDLE);

    gtx_baud_tick #(
        .RATE_W (RATE_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (line_busy),
        .rate  (cfg_rate),
        .tick  (tick)
    );

    gtx_stop_len #(
        .GAP_W (GAP_W)
    ) u_stop (
        .block_mode (cfg_block_mode),
        .two_stop   (cfg_two_stop),
        .gap        (cfg_gap),
        .stop_bits  (stop_bits)
    );

    assign tx_ready  = !r_q.hold_full && !cfg_block_mode;
    assign blk_ready = !r_q.hold_full &&  cfg_block_mode;
    assign take_byte = wr_en     && tx_ready;
    assign take_blk  = blk_valid && blk_ready;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.hold_full) begin
                    r_d.state = ST_START;
                    r_d.shreg = r_q.hold;
                end
            end
            ST_START: begin
                if (tick) begin
                    r_d.state = ST_DATA;
                    r_d.cnt   = '0;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    r_d.shreg = r_q.shreg >> 1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.state = ST_STOP;
                        r_d.cnt   = CNT_W'(stop_bits) - CNT_W'(1);
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                    // slot frees as the last data bit begins
                    if (r_q.cnt == FREE_BIT) begin
                        r_d.hold_full = 1'b0;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (r_q.cnt == '0) begin
                        if (r_q.hold_full) begin
                            r_d.state = ST_START;
                            r_d.shreg = r_q.hold;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (take_byte) begin
            r_d.hold_full = 1'b1;
            r_d.hold      = wr_data;
        end else if (take_blk) begin
            r_d.hold_full = 1'b1;
            r_d.hold      = blk_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.cnt       <= '0;
            r_q.shreg     <= '0;
            r_q.hold      <= '0;
            r_q.hold_full <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = r_q.shreg[0];
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/gtx_checker.sv
module gtx_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_block_mode,
    input logic wr_en,
    input logic blk_valid,
    input logic tx_ready,
    input logic blk_ready,
    input logic txd,
    input logic line_busy
);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_busy |-> txd)
        else $error("line low while idle");

    p_write_drops_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_ready) |=> !tx_ready)
        else $error("ready stayed high after write");

    p_start_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_ready && !line_busy) |=> ##1 !txd)
        else $error("start bit late from idle");

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready && blk_ready))
        else $error("both ready flags high");

    p_no_blk_in_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_block_mode |-> !blk_ready)
        else $error("block ready in byte mode");

    p_blk_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_ready) |=> !blk_ready)
        else $error("block ready stayed high after take");

endmodule

bind gapped_serial_tx gtx_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_block_mode (cfg_block_mode),
    .wr_en          (wr_en),
    .blk_valid      (blk_valid),
    .tx_ready       (tx_ready),
    .blk_ready      (blk_ready),
    .txd            (txd),
    .line_busy      (line_busy)
);

// File: tb/gapped_serial_tx_bench.sv
module gapped_serial_tx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_block_mode = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic [7:0] cfg_rate = 8'd3;
    logic [7:0] cfg_gap = 8'd11;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       blk_valid = 1'b0;
    logic [7:0] blk_data = 8'h00;
    logic       tx_ready, blk_ready, txd;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R11";
    bit    run_chk = 1'b0;

    always #10 clk = ~clk;

    gapped_serial_tx u_gapped_serial_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_block_mode (cfg_block_mode),
        .cfg_two_stop   (cfg_two_stop),
        .cfg_rate       (cfg_rate),
        .cfg_gap        (cfg_gap),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .tx_ready       (tx_ready),
        .blk_valid      (blk_valid),
        .blk_data       (blk_data),
        .blk_ready      (blk_ready),
        .txd            (txd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model: queue of line levels per cycle plus one waiting slot
    logic       m_q[$];
    bit         m_full = 1'b0;
    logic [7:0] m_buf = 8'h00;
    int         m_rel = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_full = 1'b0;
            m_rel  = 0;
        end else begin
            bit old_full;
            bit acc;
            old_full = m_full;
            acc = !old_full && ((wr_en && !cfg_block_mode) || (blk_valid && cfg_block_mode));
            if (m_q.size() > 0) void'(m_q.pop_front());
            if (m_rel > 0) begin
                m_rel--;
                if (m_rel == 0) m_full = 1'b0;
            end
            if (m_q.size() == 0 && old_full) begin
                int bt;
                int ns;
                bt = int'(cfg_rate) + 1;
                if (cfg_block_mode) ns = (cfg_gap >= 10) ? int'(cfg_gap) - 9 : 1;
                else                ns = cfg_two_stop ? 2 : 1;
                for (int i = 0; i < bt; i++) m_q.push_back(1'b0);
                for (int b = 0; b < 8; b++)
                    for (int i = 0; i < bt; i++) m_q.push_back(m_buf[b]);
                for (int i = 0; i < ns * bt; i++) m_q.push_back(1'b1);
                m_rel = 8 * bt;
            end
            if (acc) begin
                m_full = 1'b1;
                m_buf  = cfg_block_mode ? blk_data : wr_data;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            chk(cur_req, "txd", int'(txd), (m_q.size() > 0) ? int'(m_q[0]) : 1);
            chk("R4", "tx_ready", int'(tx_ready), int'(!m_full && !cfg_block_mode));
            chk("R8", "blk_ready", int'(blk_ready), int'(!m_full && cfg_block_mode));
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (m_q.size() != 0 || m_full);
        repeat (3) @(negedge clk);
        @(posedge clk); #2;
    endtask

    task automatic send_byte(input logic [7:0] d);
        do @(negedge clk); while (!tx_ready);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic poke(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic blk_send(input logic [7:0] d);
        bit acc;
        blk_valid = 1'b1; blk_data = d;
        do begin
            @(negedge clk); acc = blk_ready;
            @(posedge clk); #2;
        end while (!acc);
        blk_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset txd", int'(txd), 1);
        chk("R11", "reset tx_ready", int'(tx_ready), 1);
        chk("R11", "reset blk_ready", int'(blk_ready), 0);
        run_chk = 1'b1;
        @(posedge clk); #2;

        cur_req = "R1 R2 R3";
        send_byte(8'hA5);
        wait_idle();

        cur_req = "R2";
        cfg_rate = 8'd0;
        send_byte(8'h3C);
        wait_idle();
        cfg_rate = 8'd6;
        send_byte(8'h81);
        wait_idle();

        cur_req = "R6";
        cfg_rate = 8'd2; cfg_two_stop = 1'b1;
        send_byte(8'h5A);
        send_byte(8'h0F);
        wait_idle();
        cfg_two_stop = 1'b0;

        cur_req = "R4 R7";
        cfg_rate = 8'd1;
        send_byte(8'hC3);
        send_byte(8'h96);
        send_byte(8'h01);
        send_byte(8'h80);
        wait_idle();

        cur_req = "R5";
        cfg_rate = 8'd2;
        send_byte(8'h11);
        poke(8'hEE);
        repeat (5) @(posedge clk);
        #2 poke(8'h77);
        wait_idle();
        blk_valid = 1'b1; blk_data = 8'h55;
        repeat (20) @(posedge clk);
        #2 blk_valid = 1'b0;
        wait_idle();

        cur_req = "R8 R9";
        cfg_block_mode = 1'b1; cfg_gap = 8'd11;
        blk_send(8'h12);
        blk_send(8'hF0);
        blk_send(8'h6B);
        wait_idle();
        cfg_gap = 8'd14;
        blk_send(8'hA0);
        blk_send(8'h0A);
        wait_idle();
        cfg_gap = 8'd10;
        blk_send(8'h3E);
        blk_send(8'hE3);
        wait_idle();

        cur_req = "R10";
        cfg_gap = 8'd5;
        blk_send(8'h99);
        blk_send(8'h66);
        wait_idle();
        cfg_gap = 8'd9;
        blk_send(8'hFF);
        blk_send(8'h00);
        wait_idle();

        cur_req = "R5 R8";
        cfg_gap = 8'd11;
        poke(8'hDB);
        repeat (10) @(posedge clk);
        #2 blk_send(8'h24);
        poke(8'hBD);
        wait_idle();

        run_chk = 1'b0;
        summary();
    end

endmodule